// File: doc/BRIEF.md
# Banked Memory-Map Decoder

This block sits on a 16-bit processor address bus and turns each address into the one device select that should answer it. The space is split by the two top address bits into four 16K regions: working RAM at the bottom, a mixed region of battery-backed RAM and I/O, a switchable ROM window, and fixed system ROM at the top.

A small bank register, loaded by a processor write to one fixed I/O address, makes the decode depend on stored state as well as on the address. It chooses which of two 8K battery-backed RAM chips appears in a 2K window, drives that chip's two upper address lines so that eight 2K banks can be reached, enables the on-board banked ROM half, and supplies a half-select to a second ROM device. The working-RAM and ROM selects are gated by a clock-phase qualifier, so they are only active in the valid memory phase. The battery-backed RAM selects and the I/O selects are not gated.

Top module: `memmap_decoder`

## Requirements
- R1: With `phase_ok` high, `sram_lo_ce` is high exactly for addresses 0x0000-0x1FFF and `sram_hi_ce` is high exactly for 0x2000-0x3FFF.
- R2: While `phase_ok` is low, `sram_lo_ce`, `sram_hi_ce`, `brom_ce` and `srom_ce` are all low, whatever the address and bank state.
- R3: For addresses 0x7000-0x77FF, `nvram_a_ce` is high when bank bit 7 is 0 and `nvram_b_ce` is high when bank bit 7 is 1. Neither is high outside that window. `nvram_bank` always equals bank bits 6:5.
- R4: When `wr_stb` is high and `addr` is 0x7E00 at a rising clock edge, the bank register takes `wdata`. A strobe at any other address, or 0x7E00 without the strobe, leaves it unchanged.
- R5: `io_sel` is high exactly for 0x7800-0x7FFF. `opt_sel` is high only for address 0x7800.
- R6: `brom_ce` is high for 0x8000-0xBFFF only when `phase_ok` is high and bank bit 4 is 1.
- R7: With `phase_ok` high, `srom_ce` is high exactly for 0xC000-0xFFFF.
- R8: `xrom_half` always equals bank bit 0.
- R9: Asynchronous active-low reset clears the bank register to zero. This maps device A, bank 0, disables banked ROM and sets `xrom_half` to 0.
- R10: At most one of the six memory selects (`sram_lo_ce`, `sram_hi_ce`, `nvram_a_ce`, `nvram_b_ce`, `brom_ce`, `srom_ce`) is high at a time. No memory select is high for 0x4000-0x6FFF or for 0x7800-0x7FFF, which includes the bank register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| wr_stb | input | 1 | Write strobe |
| phase_ok | input | 1 | Valid memory phase qualifier |
| sram_lo_ce | output | 1 | Working RAM chip 0x0000-0x1FFF |
| sram_hi_ce | output | 1 | Working RAM chip 0x2000-0x3FFF |
| nvram_a_ce | output | 1 | Battery-backed RAM device A in window |
| nvram_b_ce | output | 1 | Battery-backed RAM device B in window |
| nvram_bank | output | 2 | Upper address lines of the battery-backed RAM |
| io_sel | output | 1 | I/O space 0x7800-0x7FFF |
| opt_sel | output | 1 | Options port at 0x7800 |
| brom_ce | output | 1 | On-board ROM lower half (banked window) |
| srom_ce | output | 1 | On-board ROM upper half (system ROM) |
| xrom_half | output | 1 | Half-select for the second ROM device |

## Verification
On every cycle the assertions check the following: at most one memory select is high, the phase gate holds, the bank register loads only on a strobed write to its address and holds otherwise, and the options select implies the I/O select. They also check that banked ROM and the RAM window fire only inside their own regions. The address-map boundaries and the way bank state steers the window and the ROM enable are shown by the bench's scenarios. These include the edge addresses of every region, the effect of several register values, ignored writes and a reset taken in mid-run.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter logic [15:0] BANK_REG_ADDR = 16'h7E00,
  parameter logic [15:0] OPT_ADDR      = 16'h7800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wr_stb,
  input  logic        phase_ok,
  output logic        sram_lo_ce,
  output logic        sram_hi_ce,
  output logic        nvram_a_ce,
  output logic        nvram_b_ce,
  output logic [1:0]  nvram_bank,
  output logic        io_sel,
  output logic        opt_sel,
  output logic        brom_ce,
  output logic        srom_ce,
  output logic        xrom_half
);

  logic       chip_q;
  logic [1:0] bank_q;
  logic       rom_en_q;
  logic       half_q;
  logic       unused_wdata;

  wire bank_we = wr_stb && (addr == BANK_REG_ADDR);
  wire nv_win  = addr[15:11] == 5'b01110;

  assign unused_wdata = ^wdata[3:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q   <= 1'b0;
      bank_q   <= 2'b00;
      rom_en_q <= 1'b0;
      half_q   <= 1'b0;
    end else if (bank_we) begin
      chip_q   <= wdata[7];
      bank_q   <= wdata[6:5];
      rom_en_q <= wdata[4];
      half_q   <= wdata[0];
    end
  end

  assign sram_lo_ce = phase_ok && (addr[15:13] == 3'b000);
  assign sram_hi_ce = phase_ok && (addr[15:13] == 3'b001);
  assign nvram_a_ce = nv_win && !chip_q;
  assign nvram_b_ce = nv_win && chip_q;
  assign nvram_bank = bank_q;
  assign io_sel     = addr[15:11] == 5'b01111;
  assign opt_sel    = addr == OPT_ADDR;
  assign brom_ce    = phase_ok && rom_en_q && (addr[15:14] == 2'b10);
  assign srom_ce    = phase_ok && (addr[15:14] == 2'b11);
  assign xrom_half  = half_q;

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        wr_stb,
  input logic        phase_ok,
  input logic        sram_lo_ce,
  input logic        sram_hi_ce,
  input logic        nvram_a_ce,
  input logic        nvram_b_ce,
  input logic [1:0]  nvram_bank,
  input logic        io_sel,
  input logic        opt_sel,
  input logic        brom_ce,
  input logic        srom_ce,
  input logic        xrom_half
);

  a_r10_one_mem: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_lo_ce, sram_hi_ce, nvram_a_ce, nvram_b_ce, brom_ce, srom_ce}));

  a_r10_io_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> !(sram_lo_ce || sram_hi_ce || nvram_a_ce || nvram_b_ce || brom_ce || srom_ce));

  a_r2_phase_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_ok |-> !(sram_lo_ce || sram_hi_ce || brom_ce || srom_ce));

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 16'h7E00) |=>
      (nvram_bank == $past(wdata[6:5]) && xrom_half == $past(wdata[0])));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && addr == 16'h7E00) |=> ($stable(nvram_bank) && $stable(xrom_half)));

  a_r5_opt_in_io: assert property (@(posedge clk) disable iff (!rst_n)
    opt_sel |-> io_sel);

  a_r6_brom_region: assert property (@(posedge clk) disable iff (!rst_n)
    brom_ce |-> (addr[15:14] == 2'b10));

  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    (nvram_a_ce || nvram_b_ce) |-> (addr[15:11] == 5'b01110));

endmodule

bind memmap_decoder memmap_decoder_chk u_chk (.*);

// File: tb/tb_memmap_decoder.sv
`timescale 1ns/1ps
module tb_memmap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr_stb = 1'b0;
  logic        phase_ok = 1'b0;
  logic        sram_lo_ce, sram_hi_ce, nvram_a_ce, nvram_b_ce;
  logic [1:0]  nvram_bank;
  logic        io_sel, opt_sel, brom_ce, srom_ce, xrom_half;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  memmap_decoder dut (.*);

  // {addr, phase_ok, expected {sram_lo,sram_hi,nv_a,nv_b,io,opt,brom,srom}} with bank = 0
  localparam int NV = 20;
  localparam logic [24:0] VEC [NV] = '{
    {16'h0000, 1'b1, 8'h80}, {16'h1FFF, 1'b1, 8'h80},
    {16'h2000, 1'b1, 8'h40}, {16'h3FFF, 1'b1, 8'h40},
    {16'h4000, 1'b1, 8'h00}, {16'h6FFF, 1'b1, 8'h00},
    {16'h7000, 1'b1, 8'h20}, {16'h77FF, 1'b1, 8'h20},
    {16'h7800, 1'b1, 8'h0C}, {16'h7801, 1'b1, 8'h08},
    {16'h7E00, 1'b1, 8'h08}, {16'h7FFF, 1'b1, 8'h08},
    {16'h8000, 1'b1, 8'h00}, {16'hBFFF, 1'b1, 8'h00},
    {16'hC000, 1'b1, 8'h01}, {16'hFFFF, 1'b1, 8'h01},
    {16'h0000, 1'b0, 8'h00}, {16'hC000, 1'b0, 8'h00},
    {16'h7000, 1'b0, 8'h20}, {16'h7800, 1'b0, 8'h0C}
  };

  function automatic logic [7:0] outs();
    return {sram_lo_ce, sram_hi_ce, nvram_a_ce, nvram_b_ce, io_sel, opt_sel, brom_ce, srom_ce};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic probe(logic [15:0] a, logic ph);
    @(negedge clk);
    addr = a; phase_ok = ph; wr_stb = 1'b0;
    #1;
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d, logic stb);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = stb; phase_ok = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset bank", {5'b0, nvram_bank, xrom_half}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][24:9], VEC[i][8]);
      check($sformatf("R1/R3/R5/R7/R10/R2 map %04h ph=%0b", VEC[i][24:9], VEC[i][8]),
            outs(), VEC[i][7:0]);
    end

    bus_write(16'h7E00, 8'hF1, 1'b1);
    check("R4 load bank", {5'b0, nvram_bank, xrom_half}, 8'h07);
    check("R8 xrom half", {7'b0, xrom_half}, 8'h01);
    probe(16'h7000, 1'b1);
    check("R3 device B", outs(), 8'h10);
    probe(16'h8000, 1'b1);
    check("R6 banked rom on", outs(), 8'h02);
    probe(16'hBFFF, 1'b1);
    check("R6 banked rom top", outs(), 8'h02);
    probe(16'h8000, 1'b0);
    check("R2 banked rom gated", outs(), 8'h00);
    probe(16'hC000, 1'b1);
    check("R10 sys rom only", outs(), 8'h01);

    bus_write(16'h7E01, 8'h00, 1'b1);
    check("R4 other addr ignored", {5'b0, nvram_bank, xrom_half}, 8'h07);
    bus_write(16'h7E00, 8'h00, 1'b0);
    check("R4 no strobe ignored", {5'b0, nvram_bank, xrom_half}, 8'h07);
    probe(16'h7000, 1'b1);
    check("R4 chip unchanged", outs(), 8'h10);

    bus_write(16'h7E00, 8'h40, 1'b1);
    check("R3 bank 2", {6'b0, nvram_bank}, 8'h02);
    check("R8 half cleared", {7'b0, xrom_half}, 8'h00);
    probe(16'h77FF, 1'b1);
    check("R3 device A", outs(), 8'h20);
    probe(16'h8000, 1'b1);
    check("R6 banked rom off", outs(), 8'h00);

    bus_write(16'h7E00, 8'hB1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async clear", {5'b0, nvram_bank, xrom_half}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    probe(16'h7000, 1'b1);
    check("R9 device A after reset", outs(), 8'h20);
    probe(16'h8000, 1'b1);
    check("R9 banked rom off after reset", outs(), 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule